// File: doc/BRIEF.md
# Receive Acknowledge and SCL Stretch Controller

This block works next to an I2C byte shifter on the receive side. It owns the acknowledge level driven in the ninth clock, the request to hold SCL low (clock stretching), and the flag that tells software a received byte is ready. The shifter supplies one-cycle SCL rise and fall events, a bit counter that runs 1 to 9, and the sampled SDA level. Software reads the byte through a data-register read strobe, which clears the flag and releases any hold.

An 8-bit control register is written and read over a simple register bus. It selects whether the ready flag rises at the 8th or the 9th SCL rising edge, and whether a wait hold is applied after the acknowledge clock. It keeps the acknowledge value to send, guarded by an enable bit in the same write, and it captures the acknowledge seen on the bus. Early flag timing stretches SCL after the 8th clock. Software can then choose ACK or NACK before the acknowledge clock runs. The noise-filter and SMBus selection bits are stored and exported to neighbouring logic.

Top module: `rxack_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `rx_full` and `scl_hold` are 0, and `sda_ack_out` is 1.
- R2: A bus write stores bits [1:0] (filter select, exported on `filt_sel`), bit 4 (acknowledge write enable), bit 5 (early flag timing), bit 6 (wait enable) and bit 7 (SMBus mode, exported on `smbus_mode`). These bits read back at the same positions on the cycle after the write.
- R3: Register bit 3 (acknowledge to send) changes on a write only when bit 4 of that same write is 1. Otherwise it keeps its value.
- R4: Register bit 2 is read-only. It takes `sda_in` at each `scl_rise` with `bit_cnt` = 9 (0 = ACK received, 1 = NACK), and a bus write leaves it unchanged.
- R5: With bit 5 = 0, `rx_full` goes to 1 one cycle after an `scl_rise` with `bit_cnt` = 9, and a fall of the 8th clock applies no hold.
- R6: With bit 5 = 1, `rx_full` goes to 1 one cycle after an `scl_rise` with `bit_cnt` = 8, and `scl_hold` goes to 1 one cycle after an `scl_fall` with `bit_cnt` = 8.
- R7: With bit 6 = 1, `scl_hold` goes to 1 one cycle after an `scl_fall` with `bit_cnt` = 9. With bit 6 = 0, that fall applies no hold.
- R8: `data_rd` clears `rx_full` and releases all holds, visible on the next cycle.
- R9: `sda_ack_out` equals register bit 3 on the cycle after `bit_cnt` is 9, and is 1 (released) otherwise.
- R10: A `bit_cnt` outside 1..9 releases any hold on the next cycle.
- R11: When a flag-set event and `data_rd` arrive in the same cycle, `rx_full` ends at 1. When a hold-set fall and `data_rd` coincide, the hold is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read value |
| scl_rise | input | 1 | One-cycle SCL rising-edge event |
| scl_fall | input | 1 | One-cycle SCL falling-edge event |
| bit_cnt | input | 4 | Current SCL clock number within the byte, 1..9 |
| sda_in | input | 1 | Sampled SDA level |
| data_rd | input | 1 | Receive data register read strobe |
| sda_ack_out | output | 1 | SDA level to drive (0 = pull low) |
| scl_hold | output | 1 | Request to hold SCL low |
| rx_full | output | 1 | Received byte ready flag |
| filt_sel | output | 2 | Stored noise-filter stage select |
| smbus_mode | output | 1 | Stored SMBus mode select |

## Verification
A wrong flag or hold state shows on `rx_full` or `scl_hold` in the cycle right after the SCL event that should have changed it. A hold that is never released stalls the bus, and the per-cycle compare reports it on the next cycle in which `scl_hold` should be 0. A lost or wrong acknowledge value shows on `sda_ack_out` one cycle after the counter reaches 9. A capture error in bit 2 shows on the next register read. Random event streams cover both flag timings and wait settings. Directed sequences pin down the same-cycle collisions and the idle-counter release.

// File: rtl/rxack_pkg.sv
package rxack_pkg;
    // control register, bit 7 down to bit 0
    typedef struct packed {
        logic       smbus;
        logic       wait_en;
        logic       early_flag;
        logic       ack_wen;
        logic       ack_tx;
        logic       ack_rx;
        logic [1:0] filt;
    } ctrl_t;
endpackage

// File: rtl/rxack_cfg_reg.sv
module rxack_cfg_reg
    import rxack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cap_en,
    input  logic       cap_val,
    output ctrl_t      ctrl_o,
    output logic       ack_tx_next
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.filt       = wr_data[1:0];
            ctrl_d.ack_wen    = wr_data[4];
            ctrl_d.early_flag = wr_data[5];
            ctrl_d.wait_en    = wr_data[6];
            ctrl_d.smbus      = wr_data[7];
            if (wr_data[4]) begin
                ctrl_d.ack_tx = wr_data[3];
            end
        end
        if (cap_en) begin
            ctrl_d.ack_rx = cap_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o      = ctrl_q;
    assign ack_tx_next = ctrl_d.ack_tx;

    // R3
    ack_tx_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[4]) |=> $stable(ctrl_q.ack_tx));
    // R4
    ack_rx_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(ctrl_q.ack_rx));
endmodule

// File: rtl/rxack_ack_unit.sv
module rxack_ack_unit #(
    parameter int CNT_W   = 4,
    parameter int ACK_CLK = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             scl_rise,
    input  logic             sda_in,
    input  logic             ack_tx_next,
    output logic             cap_en,
    output logic             cap_val,
    output logic             sda_out
);
    localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(ACK_CLK);

    logic sda_d, sda_q;

    always_comb begin
        cap_en  = scl_rise && (bit_cnt == ACK_CNT);
        cap_val = sda_in;
        sda_d   = (bit_cnt == ACK_CNT) ? ack_tx_next : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
        end else begin
            sda_q <= sda_d;
        end
    end

    assign sda_out = sda_q;

    // R9
    ack_low_only_in_ack_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_q |-> ($past(bit_cnt) == ACK_CNT));
endmodule

// File: rtl/rxack_hold_unit.sv
module rxack_hold_unit #(
    parameter int CNT_W   = 4,
    parameter int ACK_CLK = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             data_rd,
    input  logic             early_flag,
    input  logic             wait_en,
    output logic             rx_full,
    output logic             scl_hold
);
    localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(ACK_CLK);
    localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(ACK_CLK - 1);

    typedef struct packed {
        logic full;
        logic hold8;
        logic holdw;
        logic hold;
    } st_t;

    st_t st_d, st_q;
    logic in_range;
    logic [CNT_W-1:0] set_cnt;

    always_comb begin
        st_d     = st_q;
        in_range = (bit_cnt != '0) && (bit_cnt <= ACK_CNT);
        set_cnt  = early_flag ? DATA_CNT : ACK_CNT;

        if (scl_rise && in_range && (bit_cnt == set_cnt)) begin
            st_d.full = 1'b1;
        end else if (data_rd) begin
            st_d.full = 1'b0;
        end

        if (!in_range) begin
            st_d.hold8 = 1'b0;
            st_d.holdw = 1'b0;
        end else begin
            if (scl_fall && early_flag && (bit_cnt == DATA_CNT)) begin
                st_d.hold8 = 1'b1;
            end else if (data_rd) begin
                st_d.hold8 = 1'b0;
            end
            if (scl_fall && wait_en && (bit_cnt == ACK_CNT)) begin
                st_d.holdw = 1'b1;
            end else if (data_rd) begin
                st_d.holdw = 1'b0;
            end
        end
        st_d.hold = st_d.hold8 | st_d.holdw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_full  = st_q.full;
    assign scl_hold = st_q.hold;

    // R5
    full_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(scl_rise));
    // R8
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !scl_rise) |=> !st_q.full);
    // R8
    read_releases_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !scl_fall) |=> !st_q.hold);
    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_cnt == '0) || (bit_cnt > ACK_CNT)) |=> !st_q.hold);
    // R7
    no_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_flag && !wait_en && !st_q.hold) |=> !st_q.hold);
endmodule

// File: rtl/rxack_ctrl.sv
module rxack_ctrl #(
    parameter int CNT_W   = 4,
    parameter int ACK_CLK = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wr_data,
    output logic [7:0]       reg_rd_data,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             sda_in,
    input  logic             data_rd,
    output logic             sda_ack_out,
    output logic             scl_hold,
    output logic             rx_full,
    output logic [1:0]       filt_sel,
    output logic             smbus_mode
);
    import rxack_pkg::*;

    ctrl_t ctrl;
    logic  ack_tx_next;
    logic  cap_en;
    logic  cap_val;

    rxack_cfg_reg i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_data     (reg_wr_data),
        .cap_en      (cap_en),
        .cap_val     (cap_val),
        .ctrl_o      (ctrl),
        .ack_tx_next (ack_tx_next)
    );

    rxack_ack_unit #(.CNT_W(CNT_W), .ACK_CLK(ACK_CLK)) i_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_cnt     (bit_cnt),
        .scl_rise    (scl_rise),
        .sda_in      (sda_in),
        .ack_tx_next (ack_tx_next),
        .cap_en      (cap_en),
        .cap_val     (cap_val),
        .sda_out     (sda_ack_out)
    );

    rxack_hold_unit #(.CNT_W(CNT_W), .ACK_CLK(ACK_CLK)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bit_cnt    (bit_cnt),
        .data_rd    (data_rd),
        .early_flag (ctrl.early_flag),
        .wait_en    (ctrl.wait_en),
        .rx_full    (rx_full),
        .scl_hold   (scl_hold)
    );

    assign reg_rd_data = ctrl;
    assign filt_sel    = ctrl.filt;
    assign smbus_mode  = ctrl.smbus;
endmodule

// File: tb/test_rxack_ctrl.sv
`timescale 1ns/100ps
module test_rxack_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rise = 1'b0, fall = 1'b0, sda = 1'b1, rd = 1'b0;
    logic [3:0] bc = '0;
    logic       ack_o, hold_o, full_o, smb_o;
    logic [1:0] filt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxack_ctrl i_rxack_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
        .reg_rd_data(rd_data), .scl_rise(rise), .scl_fall(fall), .bit_cnt(bc),
        .sda_in(sda), .data_rd(rd), .sda_ack_out(ack_o), .scl_hold(hold_o),
        .rx_full(full_o), .filt_sel(filt_o), .smbus_mode(smb_o)
    );

    // bench model of the register and outputs
    logic [1:0] m_filt;
    logic m_rx, m_tx, m_wen, m_early, m_wait, m_smb;
    logic m_full, m_h8, m_hw, m_hold, m_sda;

    function automatic logic [7:0] exp_rd();
        return {m_smb, m_wait, m_early, m_wen, m_tx, m_rx, m_filt};
    endfunction

    always @(posedge clk) begin
        logic tx_n, h8_n, hw_n, inr;
        if (!rst_n) begin
            {m_filt, m_rx, m_tx, m_wen, m_early, m_wait, m_smb} <= '0;
            {m_full, m_h8, m_hw, m_hold} <= '0;
            m_sda <= 1'b1;
        end else begin
            tx_n = m_tx;
            if (wr_en) begin
                m_filt  <= wr_data[1:0];
                m_wen   <= wr_data[4];
                m_early <= wr_data[5];
                m_wait  <= wr_data[6];
                m_smb   <= wr_data[7];
                if (wr_data[4]) tx_n = wr_data[3];
            end
            m_tx <= tx_n;
            if (rise && bc == 4'd9) m_rx <= sda;
            if (rise && bc == (m_early ? 4'd8 : 4'd9)) m_full <= 1'b1;
            else if (rd) m_full <= 1'b0;
            inr  = (bc >= 4'd1) && (bc <= 4'd9);
            h8_n = m_h8;
            hw_n = m_hw;
            if (!inr) begin
                h8_n = 1'b0;
                hw_n = 1'b0;
            end else begin
                if (fall && m_early && bc == 4'd8) h8_n = 1'b1;
                else if (rd) h8_n = 1'b0;
                if (fall && m_wait && bc == 4'd9) hw_n = 1'b1;
                else if (rd) hw_n = 1'b0;
            end
            m_h8   <= h8_n;
            m_hw   <= hw_n;
            m_hold <= h8_n | hw_n;
            m_sda  <= (bc == 4'd9) ? tx_n : 1'b1;
        end
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        chk("R2 register", rd_data, exp_rd());
        chk("R5 rx_full", {7'd0, full_o}, {7'd0, m_full});
        chk("R7 scl_hold", {7'd0, hold_o}, {7'd0, m_hold});
        chk("R9 sda_ack_out", {7'd0, ack_o}, {7'd0, m_sda});
        chk("R2 exports", {5'd0, smb_o, filt_o}, {5'd0, exp_rd()[7], exp_rd()[1:0]});
        wr_en = 1'b0; rise = 1'b0; fall = 1'b0; rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd4321);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 reg", rd_data, 8'h00);
        chk("R1 full", {7'd0, full_o}, 8'h00);
        chk("R1 hold", {7'd0, hold_o}, 8'h00);
        chk("R1 ack", {7'd0, ack_o}, 8'h01);

        // R3 protected write: bit3 without bit4
        wr(8'h08);
        chk("R3 protect", rd_data, 8'h00);
        wr(8'h18);
        chk("R3 enabled", rd_data, 8'h18);
        wr(8'h03);
        chk("R3 kept", rd_data, 8'h0B);
        // R4 bit2 read-only
        wr(8'h04);
        chk("R4 readonly", {5'd0, rd_data[2], 2'd0}, 8'h00);
        bc = 4'd9; sda = 1'b1; rise = 1'b1;
        cyc();
        chk("R4 capture nack", {7'd0, rd_data[2]}, 8'h01);
        chk("R5 late flag", {7'd0, full_o}, 8'h01);
        chk("R9 drive nack", {7'd0, ack_o}, 8'h01);
        rd = 1'b1;
        cyc();
        chk("R8 clear", {7'd0, full_o}, 8'h00);

        // R6 early timing, ack to send = 0
        bc = 4'd1;
        wr(8'h30);
        bc = 4'd8; rise = 1'b1;
        cyc();
        chk("R6 early flag", {7'd0, full_o}, 8'h01);
        fall = 1'b1;
        cyc();
        chk("R6 hold", {7'd0, hold_o}, 8'h01);
        rd = 1'b1;
        cyc();
        chk("R8 release", {7'd0, hold_o}, 8'h00);
        bc = 4'd9;
        cyc();
        chk("R9 drive ack", {7'd0, ack_o}, 8'h00);

        // R7 wait hold, R11 set beats read, R10 idle release
        wr(8'h40);
        fall = 1'b1; rd = 1'b1;
        cyc();
        chk("R11 hold wins", {7'd0, hold_o}, 8'h01);
        chk("R7 wait hold", {7'd0, hold_o}, 8'h01);
        bc = 4'd0;
        cyc();
        chk("R10 idle release", {7'd0, hold_o}, 8'h00);
        bc = 4'd9; rise = 1'b1; rd = 1'b1;
        wr_en = 1'b0;
        cyc();
        chk("R11 flag wins", {7'd0, full_o}, 8'h01);
        wr(8'h00);
        fall = 1'b1;
        cyc();
        chk("R7 no wait hold", {7'd0, hold_o}, 8'h00);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            bc    = (r < 90) ? 4'($urandom_range(1, 9)) : 4'($urandom_range(10, 15)) & {4{r[0]}};
            rise  = ($urandom_range(0, 3) == 0);
            fall  = !rise && ($urandom_range(0, 3) == 0);
            sda   = $urandom_range(0, 1);
            rd    = ($urandom_range(0, 7) == 0);
            wr_en = ($urandom_range(0, 15) == 0);
            wr_data = 8'($urandom());
            cyc();
        end
        finish_run();
    end
endmodule